// File: doc/BRIEF.md
# USB Start-of-Frame Timing Monitor

This block watches start-of-frame (SOF) activity for a full-speed USB device. An upstream packet decoder gives it a one-cycle pulse for each SOF token that has already passed its checks, together with the 11-bit frame number that token carries. The monitor keeps a local copy of the current frame number and runs a frame watchdog timer. If the host's SOF does not arrive within one nominal frame period plus a tolerance, the monitor produces a synthetic SOF pulse so that frame-based logic downstream keeps running.

Software supplies a frame number to watch for. The monitor raises three sticky event flags: one for a real SOF, one when the current frame number equals the watched value, and one when a synthetic SOF was produced. Each flag has a mask bit. A write-one-to-clear strobe vector clears the flags. The interrupt output is high while any unmasked flag is pending.

The watchdog stays idle after reset until the first real SOF has been seen. A device that has not yet been enumerated therefore never produces synthetic frames.

Top module: `sof_frame_watch`

## Requirements
- R1: A `sof_valid` pulse sampled at a clock edge sets `status[0]` (real-SOF flag). The flag reads 1 from that edge onward.
- R2: `status[1]` (frame-match flag) is set at the edge where a real SOF carries a `sof_frame` equal to `match_frame`. It is also set at the edge where a synthetic SOF advances `frame_now` to a value equal to `match_frame`.
- R3: With LIMIT = FRAME_CYCLES + TOL_CYCLES, `art_sof` is high for exactly one cycle when LIMIT clock edges have passed since the last real or synthetic SOF without a real SOF. `status[2]` (synthetic-SOF flag) is set at the edge that ends that cycle. The timer then restarts, so synthetic SOFs repeat every LIMIT cycles.
- R4: `frame_now` loads `sof_frame` at each real SOF. At each synthetic SOF it increments modulo 2048, so 2047 is followed by 0.
- R5: Every flag holds at 1 until it is cleared. A 1 in bit i of `status_clr` clears flag i at that edge. If a set event for the same flag occurs at the same edge, the set wins and the flag stays 1.
- R6: `irq` is the OR of `status & irq_mask`. It follows mask changes in the same cycle.
- R7: No synthetic SOF is produced after reset until a first real SOF has been sampled.
- R8: A synchronous active-low reset clears `status`, `frame_now`, the timer and the armed state. As a result, `irq` and `art_sof` read 0.
- R9: If a real SOF arrives in the cycle in which the timer would expire, no synthetic SOF is produced and the timer restarts from the real SOF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof_valid | input | 1 | One-cycle pulse for each checked SOF token |
| sof_frame | input | 11 | Frame number carried by the SOF token |
| match_frame | input | 11 | Frame number that sets the match flag |
| irq_mask | input | 3 | Per-flag interrupt enable (bit0 SOF, bit1 match, bit2 synthetic) |
| status_clr | input | 3 | Write-one-to-clear strobes, same bit order |
| status | output | 3 | Sticky flags: bit0 SOF, bit1 match, bit2 synthetic SOF |
| irq | output | 1 | Masked OR of the flags |
| frame_now | output | 11 | Local frame number |
| art_sof | output | 1 | Synthetic SOF pulse |

## Verification
The flag and frame number results of a SOF pulse, a timer expiry or a clear strobe all become visible in the cycle after the edge that samples the event. `art_sof` and `irq` are combinational and reflect the current cycle's state and inputs. The bench's behavioural model advances at each rising edge from the sampled inputs. Inputs are driven at the falling edge, and every output is compared 5 ns after the falling edge, so each result is checked in exactly the cycle it is due. The coincident-expiry case is placed so that the second SOF lands on the LIMIT-th edge after the first.

// File: rtl/sof_mon_pkg.sv
// Shared constants for the SOF timing monitor: field widths and flag bit positions.
package sof_mon_pkg;
    localparam int FN_W      = 11;  // USB frame number width
    localparam int NUM_FLAGS = 3;   // number of sticky flags
    localparam int FLG_SOF   = 0;   // real SOF seen
    localparam int FLG_MATCH = 1;   // frame number equals watched value
    localparam int FLG_ART   = 2;   // synthetic SOF produced
endpackage

// File: rtl/sof_wd_timer.sv
// Frame watchdog timer. Counts clock edges since the last real or synthetic SOF.
// It fires art_fire in the cycle whose closing edge is the LIMIT-th one.
// Assumes sof_valid is a single-cycle pulse. The timer is idle until the first real SOF.
module sof_wd_timer #(
    parameter int FRAME_CYCLES = 48000,
    parameter int TOL_CYCLES   = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sof_valid,
    output logic art_fire
);
    localparam int LIMIT = FRAME_CYCLES + TOL_CYCLES;
    localparam int CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] count;
    logic          armed;

    // Expiry: armed, count at its last value, and no real SOF in the same cycle.
    assign art_fire = armed && !sof_valid && (count == LAST);

    // Counter and arm state: a real SOF restarts and arms; expiry wraps to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            armed <= 1'b0;
        end else if (sof_valid) begin
            count <= '0;
            armed <= 1'b1;
        end else if (armed) begin
            count <= art_fire ? '0 : count + 1'b1;
        end
    end

    assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST);
    assert_restart_on_sof_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sof_valid |=> (count == '0) && armed);
    assert_idle_unarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (count == '0));
endmodule

// File: rtl/sof_frame_track.sv
// Local frame number keeper and match comparator. It loads the received number
// on a real SOF and increments modulo 2^FN_W on a synthetic SOF. match_hit flags
// the number that becomes current at this edge.
module sof_frame_track
    import sof_mon_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sof_valid,
    input  logic [FN_W-1:0] sof_frame,
    input  logic            art_fire,
    input  logic [FN_W-1:0] match_frame,
    output logic [FN_W-1:0] frame_now,
    output logic            match_hit
);
    logic [FN_W-1:0] frame_q;
    logic [FN_W-1:0] frame_inc;

    assign frame_inc = frame_q + 1'b1;
    assign frame_now = frame_q;

    // Compare whichever number is about to become current.
    always_comb begin
        if (sof_valid)     match_hit = (sof_frame == match_frame);
        else if (art_fire) match_hit = (frame_inc == match_frame);
        else               match_hit = 1'b0;
    end

    // Frame register: load on real SOF, step on synthetic SOF.
    always_ff @(posedge clk) begin
        if (!rst_n)         frame_q <= '0;
        else if (sof_valid) frame_q <= sof_frame;
        else if (art_fire)  frame_q <= frame_inc;
    end

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (art_fire && !sof_valid && (frame_q == {FN_W{1'b1}})) |=> (frame_q == '0));
    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sof_valid |=> (frame_q == $past(sof_frame)));
endmodule

// File: rtl/sof_flag_bank.sv
// Sticky flag register bank with write-one-to-clear and per-bit mask.
// A set at the same edge as a clear wins. irq is the masked OR of the flags.
module sof_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] status,
    output logic         irq
);
    // Masked interrupt request.
    assign irq = |(status & mask);

    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky bit: set dominates clear, otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n)         status[i] <= 1'b0;
            else if (set_ev[i]) status[i] <= 1'b1;
            else if (clr[i])    status[i] <= 1'b0;
        end

        assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
            set_ev[i] |=> status[i]);
        assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !clr[i]) |=> status[i]);
        assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set_ev[i]) |=> !status[i]);
    end
endmodule

// File: rtl/sof_frame_watch.sv
// Top level of the SOF timing monitor. It connects the watchdog timer, the frame
// tracker and the flag bank. Assumes sof_valid comes from an upstream decoder that
// has already validated the token. All events register on the next edge.
module sof_frame_watch
    import sof_mon_pkg::*;
#(
    parameter int FRAME_CYCLES = 48000,
    parameter int TOL_CYCLES   = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sof_valid,
    input  logic [FN_W-1:0]      sof_frame,
    input  logic [FN_W-1:0]      match_frame,
    input  logic [NUM_FLAGS-1:0] irq_mask,
    input  logic [NUM_FLAGS-1:0] status_clr,
    output logic [NUM_FLAGS-1:0] status,
    output logic                 irq,
    output logic [FN_W-1:0]      frame_now,
    output logic                 art_sof
);
    logic                 art_fire;
    logic                 match_hit;
    logic [NUM_FLAGS-1:0] set_ev;

    sof_wd_timer #(.FRAME_CYCLES(FRAME_CYCLES), .TOL_CYCLES(TOL_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .sof_valid(sof_valid), .art_fire(art_fire)
    );

    sof_frame_track u_track (
        .clk(clk), .rst_n(rst_n), .sof_valid(sof_valid), .sof_frame(sof_frame),
        .art_fire(art_fire), .match_frame(match_frame),
        .frame_now(frame_now), .match_hit(match_hit)
    );

    // Gather the per-flag set events.
    always_comb begin
        set_ev            = '0;
        set_ev[FLG_SOF]   = sof_valid;
        set_ev[FLG_MATCH] = match_hit;
        set_ev[FLG_ART]   = art_fire;
    end

    sof_flag_bank #(.N(NUM_FLAGS)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr(status_clr),
        .mask(irq_mask), .status(status), .irq(irq)
    );

    assign art_sof = art_fire;

    assert_art_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        art_sof |=> !art_sof);
    assert_art_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        art_sof |=> status[FLG_ART]);
    assert_sof_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sof_valid |=> status[FLG_SOF]);
    assert_no_art_with_sof_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sof_valid |-> !art_sof);
endmodule

// File: tb/sof_frame_watch_test.sv
module sof_frame_watch_test;
    localparam int FC    = 40;
    localparam int TC    = 4;
    localparam int LIMIT = FC + TC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof_valid = 1'b0;
    logic [10:0] sof_frame = '0;
    logic [10:0] match_frame = '0;
    logic [2:0]  irq_mask = '0;
    logic [2:0]  status_clr = '0;
    logic [2:0]  status;
    logic        irq;
    logic [10:0] frame_now;
    logic        art_sof;

    int n_cmp = 0;
    int n_bad = 0;
    bit model_ok = 0;
    int art_seen = 0;

    // behavioural reference state
    bit m_armed;
    int m_cnt;
    int m_frame;
    bit [2:0] m_st;

    sof_frame_watch #(.FRAME_CYCLES(FC), .TOL_CYCLES(TC)) uut (
        .clk(clk), .rst_n(rst_n), .sof_valid(sof_valid), .sof_frame(sof_frame),
        .match_frame(match_frame), .irq_mask(irq_mask), .status_clr(status_clr),
        .status(status), .irq(irq), .frame_now(frame_now), .art_sof(art_sof)
    );

    always #10 clk = ~clk;

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // model step at each rising edge
    always @(posedge clk) begin
        bit fire, mhit;
        if (!rst_n) begin
            m_armed = 0; m_cnt = 0; m_frame = 0; m_st = 0; model_ok = 1;
        end else begin
            fire = m_armed && !sof_valid && (m_cnt == LIMIT - 1);
            if (sof_valid) mhit = (int'(sof_frame) == int'(match_frame));
            else mhit = fire && (((m_frame + 1) % 2048) == int'(match_frame));
            m_st = (m_st & ~status_clr) | {fire, mhit, sof_valid};
            if (sof_valid) begin
                m_frame = sof_frame; m_cnt = 0; m_armed = 1;
            end else if (m_armed) begin
                if (fire) begin m_frame = (m_frame + 1) % 2048; m_cnt = 0; end
                else m_cnt++;
            end
        end
    end

    // compare every cycle, away from both edges
    always @(negedge clk) begin
        #5;
        if (model_ok) begin
            bit exp_art;
            exp_art = m_armed && !sof_valid && (m_cnt == LIMIT - 1);
            cmp("R1 sof flag", 32'(status[0]), 32'(m_st[0]));
            cmp("R2 match flag", 32'(status[1]), 32'(m_st[1]));
            cmp("R3 art flag", 32'(status[2]), 32'(m_st[2]));
            cmp("R3 art pulse", 32'(art_sof), 32'(exp_art));
            cmp("R4 frame", 32'(frame_now), 32'(m_frame));
            cmp("R6 irq", 32'(irq), 32'(|(m_st & irq_mask)));
            if (art_sof === 1'b1) art_seen++;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sof(input int fr);
        @(negedge clk); sof_valid = 1'b1; sof_frame = 11'(fr);
        @(negedge clk); sof_valid = 1'b0;
    endtask

    task automatic clr(input logic [2:0] b);
        @(negedge clk); status_clr = b;
        @(negedge clk); status_clr = '0;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        #5;
        // R8: reset state
        cmp("R8 status", 32'(status), 0);
        cmp("R8 frame", 32'(frame_now), 0);
        cmp("R8 irq", 32'(irq), 0);
        cmp("R8 art", 32'(art_sof), 0);
        // R7: no synthetic SOF before the first real one
        idle(3 * LIMIT);
        cmp("R7 art before first sof", art_seen, 0);
        irq_mask = 3'b111;
        match_frame = 11'd7;
        sof(5);                      // R1
        idle(5);
        sof(6);
        clr(3'b001);                 // R5 clear
        sof(7);                      // R2 real match
        idle(3);
        irq_mask = 3'b000;           // R6 masked
        idle(2);
        irq_mask = 3'b010;
        clr(3'b011);
        irq_mask = 3'b111;
        match_frame = 11'd9;
        idle(2 * LIMIT + 4);         // R3, R4: two synthetic SOFs, match on 9
        sof(2047);
        match_frame = 11'd0;
        idle(LIMIT + 2);             // R4 wrap to 0, R2 match on synthetic
        cmp("R4 wrap frame", 32'(frame_now), 0);
        // R5: clear in same edge as a set event
        @(negedge clk); sof_valid = 1'b1; sof_frame = 11'd100; status_clr = 3'b111;
        @(negedge clk); sof_valid = 1'b0; status_clr = '0;
        #5 cmp("R5 set wins", 32'(status[0]), 1);
        // R9: real SOF exactly on the expiry edge
        sof(200);
        clr(3'b111);
        art_seen = 0;
        idle(LIMIT - 4);
        sof(201);
        idle(3);
        cmp("R9 no art on coincident sof", art_seen, 0);
        cmp("R9 art flag clear", 32'(status[2]), 0);
        idle(LIMIT + 3);
        // mid-run reset, R8
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #5 cmp("R8 reset again", 32'(status), 0);
        idle(2 * LIMIT);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule